// File: doc/BRIEF.md
# Sensor Row and Frame Readout Window Timer

This block produces the readout timing for one frame of an image sensor. A row-start strobe opens a pixel-valid window for the row. The sensor moves two pixels per clock, so the window counts pixel pairs. It closes once a programmed pair count is reached. Software programs the pixel limit as half the region-of-interest width minus one. A window that is open for limit+1 clocks therefore covers the whole region.

A frame-start strobe clears a line counter. The counter steps once for each row-clock strobe, not on every clock. When it reaches the programmed line limit, the block emits a one-clock last-line pulse. The line limit is the number of lines wanted minus one. The counter then stays at the terminal value until the next frame-start strobe. The pixel datapath and the analog side of readout are handled elsewhere.

Top module: `readout_window_gen`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `pix_valid` and `last_line` are 0 and `pix_cnt` and `line_cnt` are 0.
- R2: A `row_sync` sampled high on a clock edge makes `pix_valid` 1 and `pix_cnt` 0 after that edge.
- R3: While the window is open and `pix_cnt` differs from `pix_limit`, each clock raises `pix_cnt` by one. The window closes on the edge after `pix_cnt` equals `pix_limit`, so `pix_valid` is high for exactly `pix_limit`+1 clocks, including `pix_limit` = 0.
- R4: A `row_sync` that arrives while the window is open restarts it, with `pix_cnt` back at 0 and `pix_valid` still high.
- R5: Once the window is closed and no `row_sync` arrives, `pix_valid` stays 0 and `pix_cnt` keeps its last value.
- R6: A `frame_sync` sampled high clears `line_cnt` to 0 after that edge.
- R7: After a frame start and before the terminal count, each cycle with `row_clk` high raises `line_cnt` by one. Cycles without `row_clk` leave it unchanged.
- R8: `last_line` is high for exactly one clock. It rises after the edge on which `line_cnt` becomes equal to `line_limit`. When `line_limit` is 0, it rises after the `frame_sync` edge itself.
- R9: After the terminal count, `row_clk` strobes are ignored: `line_cnt` holds and no further `last_line` appears until the next `frame_sync`.
- R10: When `frame_sync` and `row_clk` are both high in the same cycle, the frame start wins and `line_cnt` becomes 0.
- R11: After reset and before the first `frame_sync`, `row_clk` strobes are ignored and `line_cnt` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_sync | input | 1 | Row-start strobe that opens the pixel window |
| frame_sync | input | 1 | Frame-start strobe that clears the line counter |
| row_clk | input | 1 | Row-advance strobe for the line counter |
| pix_limit | input | 12 | Last pixel-pair index of a row (ROI width / 2 − 1) |
| line_limit | input | 12 | Last line index of a frame (lines − 1) |
| pix_valid | output | 1 | High while the row's pixel window is open |
| pix_cnt | output | 12 | Current pixel-pair index |
| line_cnt | output | 12 | Current line index |
| last_line | output | 1 | One-clock pulse when the last line is reached |

## Verification
The inline properties check, on every cycle, the local stepping rules:
- a row start opens the window at zero;
- an open window counts up by one or closes at the limit;
- a frame start clears the line counter;
- the line counter is frozen and silent once the terminal count is reached;
- the last-line pulse never lasts two clocks.

Some behaviours depend on a whole sequence of inputs, and only the bench's scenarios show them:
- the exact window length for several limits, including zero;
- a row restart in the middle of a window;
- row-clock strobes ignored before the first frame start;
- a frame start and a row clock arriving together;
- the pulse for a zero line limit.

A cycle-level reference model in the bench supplies the expected values for these scenarios.

// File: rtl/readout_window_gen.sv
module readout_window_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_sync,
  input  logic          frame_sync,
  input  logic          row_clk,
  input  logic [CW-1:0] pix_limit,
  input  logic [CW-1:0] line_limit,
  output logic          pix_valid,
  output logic [CW-1:0] pix_cnt,
  output logic [CW-1:0] line_cnt,
  output logic          last_line
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          frame_done;
  logic [CW-1:0] line_next;
  logic          pix_at_end;

  assign pix_at_end = (pix_cnt == pix_limit);
  assign line_next  = line_cnt + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_cnt   <= '0;
    end else if (row_sync) begin
      pix_valid <= 1'b1;
      pix_cnt   <= '0;
    end else if (pix_valid) begin
      if (pix_at_end) pix_valid <= 1'b0;
      else            pix_cnt   <= pix_cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt   <= '0;
      frame_done <= 1'b1;
      last_line  <= 1'b0;
    end else if (frame_sync) begin
      line_cnt   <= '0;
      frame_done <= (line_limit == '0);
      last_line  <= (line_limit == '0);
    end else if (row_clk && !frame_done) begin
      line_cnt   <= line_next;
      frame_done <= (line_next == line_limit);
      last_line  <= (line_next == line_limit);
    end else begin
      last_line  <= 1'b0;
    end
  end

  AST_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    row_sync |=> (pix_valid && pix_cnt == '0)); // R2

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !row_sync && pix_cnt != pix_limit) |=>
      (pix_valid && pix_cnt == $past(pix_cnt) + ONE)); // R3

  AST_PIX_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !row_sync && pix_cnt == pix_limit) |=> !pix_valid); // R3

  AST_PIX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !row_sync) |=> (!pix_valid && $stable(pix_cnt))); // R5

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (line_cnt == '0)); // R6

  AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_sync) |=> ($stable(line_cnt) && !last_line)); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_line && !frame_sync) |=> !last_line); // R8

  AST_PULSE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (last_line && !$past(frame_sync)) |-> (line_cnt == $past(line_cnt) + ONE)); // R8

endmodule

// File: tb/readout_window_gen_test.sv
module readout_window_gen_test;
  localparam int CW = 12;

  typedef struct {
    logic          v;
    logic [CW-1:0] p;
    logic [CW-1:0] l;
    logic          ll;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          row_sync = 1'b0, frame_sync = 1'b0, row_clk = 1'b0;
  logic [CW-1:0] pix_limit = '0, line_limit = '0;
  logic          pix_valid, last_line;
  logic [CW-1:0] pix_cnt, line_cnt;

  int checks = 0, failures = 0;
  bit drv_done = 1'b0;
  exp_t q[$];

  logic          mv = 0, mlast = 0, mdone = 1;
  logic [CW-1:0] mp = '0, ml = '0;

  readout_window_gen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .row_sync(row_sync), .frame_sync(frame_sync),
    .row_clk(row_clk), .pix_limit(pix_limit), .line_limit(line_limit),
    .pix_valid(pix_valid), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .last_line(last_line)
  );

  always #10 clk = ~clk;

  task automatic cyc(input logic rs, input logic fs, input logic rc, input string tag);
    exp_t e;
    @(negedge clk);
    row_sync = rs; frame_sync = fs; row_clk = rc;
    if (rs) begin mv = 1; mp = '0; end
    else if (mv) begin
      if (mp == pix_limit) mv = 0; else mp = mp + 1;
    end
    if (fs) begin ml = '0; mdone = (line_limit == 0); mlast = mdone; end
    else if (rc && !mdone) begin
      ml = ml + 1; mlast = (ml == line_limit); mdone = mlast;
    end else mlast = 0;
    e.v = mv; e.p = mp; e.l = ml; e.ll = mlast; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (pix_valid !== e.v || pix_cnt !== e.p || line_cnt !== e.l || last_line !== e.ll) begin
          failures++;
          $display("FAIL %s: got v=%0b p=%0d l=%0d ll=%0b exp v=%0b p=%0d l=%0d ll=%0b",
                   e.tag, pix_valid, pix_cnt, line_cnt, last_line, e.v, e.p, e.l, e.ll);
        end
      end
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    checks++;
    if (pix_valid !== 0 || pix_cnt !== 0 || line_cnt !== 0 || last_line !== 0) begin
      failures++;
      $display("FAIL R1: got v=%0b p=%0d l=%0d ll=%0b exp all zero",
               pix_valid, pix_cnt, line_cnt, last_line);
    end
    rst_n = 1'b1;
    cyc(0, 0, 0, "R1");
    pix_limit = 12'd3;
    cyc(1, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R5");
    pix_limit = 12'd0;
    cyc(1, 0, 0, "R2");
    cyc(0, 0, 0, "R3");
    cyc(0, 0, 0, "R5");
    pix_limit = 12'd5;
    cyc(1, 0, 0, "R2");
    cyc(0, 0, 0, "R3");
    cyc(0, 0, 0, "R3");
    cyc(1, 0, 0, "R4");
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, "R4");
    cyc(0, 0, 1, "R11");
    cyc(0, 0, 1, "R11");
    line_limit = 12'd3;
    cyc(0, 1, 0, "R6");
    cyc(0, 0, 1, "R7");
    cyc(0, 0, 0, "R7");
    cyc(0, 0, 0, "R7");
    cyc(0, 0, 1, "R7");
    cyc(0, 0, 1, "R8");
    cyc(0, 0, 0, "R8");
    cyc(0, 0, 1, "R9");
    cyc(0, 0, 1, "R9");
    cyc(1, 1, 1, "R10");
    cyc(0, 0, 1, "R10");
    cyc(0, 0, 0, "R7");
    line_limit = 12'd0;
    cyc(0, 1, 0, "R8");
    cyc(0, 0, 0, "R8");
    cyc(0, 0, 1, "R9");
    line_limit = 12'd1;
    cyc(0, 1, 1, "R10");
    cyc(0, 0, 1, "R8");
    cyc(0, 0, 0, "R8");
    repeat (2) @(negedge clk);
    drv_done = 1'b1;
  end

  initial begin : finisher
    fork
      begin wait (drv_done && q.size() == 0); #20; end
      begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule